// File: doc/BRIEF.md
# Four-Bit Successive-Approximation Conversion Sequencer

This block is the digital half of a 4-bit analog-to-digital converter that works by successive comparison against a resistor-string reference. A one-cycle start request, together with a 3-bit channel code, selects one of six analog inputs through a one-hot select vector. The block then drives a 4-bit reference code towards the ladder and reads a single comparator bit once per step, deciding one bit per step from the most significant down to the least significant.

A conversion opens with the reference code at 1000B. The comparator reports 1 when the selected input is at or above the ladder voltage. At the end of each settling window the bit under test is kept when the comparator reads 1 and cleared when it reads 0, and the next lower bit is raised for the following trial. After the last bit the final code appears on the result port with a one-cycle done strobe. Channel inputs 1 to 5 share their package pins with general-purpose port bits; this does not affect the sequencer. While idle, software may load the reference code directly, for example to hold a fixed threshold.

Top module: `sar_adc_seq`

## Requirements
- R1: After synchronous reset, ref_code_o, result_o, chan_sel_o, busy_o, done_o and err_o are all zero.
- R2: A start request seen while idle with a channel code below 6 raises busy_o and sets ref_code_o to 1000B on the next cycle.
- R3: Each step holds ref_code_o unchanged for SETTLE_CYC cycles after it is updated, and samples cmp_i on the last of those cycles.
- R4: At each sample, the bit under test is set equal to cmp_i. If that bit is not bit 0, the next lower bit is set to 1 for the following step.
- R5: done_o is high for exactly one cycle, 4*SETTLE_CYC cycles after the start edge. In the same cycle, result_o shows the decided code and busy_o is low. With an ideal comparator, that code equals the selected input level.
- R6: While busy, chan_sel_o is one-hot, with bit k set for channel code k (000 selects input 0, 101 selects input 5). While idle, chan_sel_o is zero.
- R7: A start request with channel code 110 or 111 sets err_o on the next cycle and does not start a conversion: busy_o stays low and no done_o follows.
- R8: A start request during a conversion is ignored. The channel, the latency and the result stay those of the running conversion.
- R9: While idle with no start request, ref_we_i loads ref_wdata_i into ref_code_o on the next cycle. While busy, the write is ignored.
- R10: A start request with a valid channel clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle conversion request |
| chan_i | input | 3 | Channel code, valid codes 0 to 5 |
| cmp_i | input | 1 | Comparator result, 1 when input is at or above reference |
| ref_we_i | input | 1 | Direct reference-code write enable (honoured only while idle) |
| ref_wdata_i | input | 4 | Direct reference-code write data |
| ref_code_o | output | 4 | Reference code driven to the ladder DAC |
| chan_sel_o | output | 6 | One-hot analog input select |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 4 | Last converted code |
| err_o | output | 1 | Set by a start request with an unused channel code |

## Verification
A wrong bit index or a wrong keep/clear decision shows up as a wrong result_o at the done strobe. For inputs near a code boundary it also shows up as a wrong ref_code_o one cycle after the faulty sample. A settling counter that is off by one moves done_o earlier or later than 4*SETTLE_CYC cycles, and the bench sees this on the first conversion. A latched channel that is corrupt or that gets updated by a second start request makes the ideal comparator model follow the wrong input, so the final code differs within one conversion.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;

    // Width of a down-counter range 0..n-1, never below one bit
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adc_chan_decode.sv
module adc_chan_decode #(
    parameter int SEL_W  = 3,
    parameter int NUM_CH = 6
) (
    input  logic [SEL_W-1:0]  code_i,
    output logic              valid_o,
    output logic [NUM_CH-1:0] onehot_o
);
    assign valid_o = (int'(code_i) < NUM_CH);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
        assign onehot_o[k] = (int'(code_i) == k);
    end
endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer
    import adc_sar_pkg::*;
#(
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expire_o
);
    localparam int CNT_W = cnt_width(SETTLE_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: counter never exceeds the settling window
    a_r3_window_bound: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q <= LAST));
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
    import adc_sar_pkg::*;
#(
    parameter int RES_BITS = 4,
    parameter int NUM_CH   = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                chan_ok_i,
    input  logic [NUM_CH-1:0]   chan_hot_i,
    input  logic                cmp_i,
    input  logic                expire_i,
    input  logic                ref_we_i,
    input  logic [RES_BITS-1:0] ref_wdata_i,
    output logic [RES_BITS-1:0] ref_code_o,
    output logic [NUM_CH-1:0]   chan_sel_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                err_o
);
    localparam int IDX_W = cnt_width(RES_BITS);
    localparam logic [RES_BITS-1:0] FIRST_CODE = RES_BITS'(1) << (RES_BITS - 1);
    localparam logic [IDX_W-1:0]    TOP_IDX    = IDX_W'(RES_BITS - 1);

    seq_state_e          state_q;
    logic [RES_BITS-1:0] trial_q;
    logic [IDX_W-1:0]    idx_q;
    logic [NUM_CH-1:0]   sel_q;
    logic [RES_BITS-1:0] result_q;
    logic                done_q;
    logic                err_q;

    logic                busy;
    logic                last_step;
    logic [RES_BITS-1:0] decided;

    assign busy      = (state_q == SEQ_CONV);
    assign last_step = (idx_q == '0);

    always_comb begin
        decided        = trial_q;
        decided[idx_q] = cmp_i;
        if (!last_step) begin
            decided[idx_q - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            trial_q  <= '0;
            idx_q    <= '0;
            sel_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        if (chan_ok_i) begin
                            state_q <= SEQ_CONV;
                            trial_q <= FIRST_CODE;
                            idx_q   <= TOP_IDX;
                            sel_q   <= chan_hot_i;
                            err_q   <= 1'b0;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end else if (ref_we_i) begin
                        trial_q <= ref_wdata_i;
                    end
                end
                SEQ_CONV: begin
                    if (expire_i) begin
                        trial_q <= decided;
                        if (last_step) begin
                            result_q <= decided;
                            done_q   <= 1'b1;
                            state_q  <= SEQ_IDLE;
                            sel_q    <= '0;
                        end else begin
                            idx_q <= idx_q - 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign ref_code_o = trial_q;
    assign chan_sel_o = sel_q;
    assign busy_o     = busy;
    assign done_o     = done_q;
    assign result_o   = result_q;
    assign err_o      = err_q;

    // R2: valid start from idle loads the first trial code
    a_r2_first_code: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i && chan_ok_i) |=> (busy && trial_q == FIRST_CODE));

    // R3: reference stays put inside a settling window
    a_r3_ref_steady: assert property (@(posedge clk) disable iff (rst)
        (busy && !expire_i) |=> $stable(trial_q));

    // R4: decided bit follows comparator, next lower bit raised
    a_r4_bit_decision: assert property (@(posedge clk) disable iff (rst)
        (busy && expire_i && !last_step) |=>
            (trial_q[$past(idx_q)] == $past(cmp_i)) && trial_q[$past(idx_q) - 1'b1]);

    // R5: done is a single-cycle strobe and ends the conversion
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy);

    // R6: select vector one-hot when busy, clear when idle
    a_r6_sel_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> $onehot(sel_q));
    a_r6_sel_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sel_q == '0));

    // R7: unused channel code flags error and stays idle
    a_r7_bad_chan: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i && !chan_ok_i) |=> (err_q && !busy));

    // R8: channel held through the conversion
    a_r8_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !(expire_i && last_step)) |=> $stable(sel_q));

    // R9: direct write while idle lands in the reference code
    a_r9_direct_write: assert property (@(posedge clk) disable iff (rst)
        (!busy && ref_we_i && !start_i) |=> (trial_q == $past(ref_wdata_i)));

    // R10: valid start clears the error flag
    a_r10_err_clear: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i && chan_ok_i) |=> !err_q);
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import adc_sar_pkg::*;
#(
    parameter int RES_BITS   = 4,
    parameter int NUM_CH     = 6,
    parameter int SEL_W      = 3,
    parameter int SETTLE_CYC = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SEL_W-1:0]    chan_i,
    input  logic                cmp_i,
    input  logic                ref_we_i,
    input  logic [RES_BITS-1:0] ref_wdata_i,
    output logic [RES_BITS-1:0] ref_code_o,
    output logic [NUM_CH-1:0]   chan_sel_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                err_o
);
    logic              chan_ok;
    logic [NUM_CH-1:0] chan_hot;
    logic              expire;
    logic              busy;

    adc_chan_decode #(.SEL_W(SEL_W), .NUM_CH(NUM_CH)) u_decode (
        .code_i   (chan_i),
        .valid_o  (chan_ok),
        .onehot_o (chan_hot)
    );

    adc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (busy),
        .expire_o (expire)
    );

    adc_sar_ctrl #(.RES_BITS(RES_BITS), .NUM_CH(NUM_CH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .chan_ok_i   (chan_ok),
        .chan_hot_i  (chan_hot),
        .cmp_i       (cmp_i),
        .expire_i    (expire),
        .ref_we_i    (ref_we_i),
        .ref_wdata_i (ref_wdata_i),
        .ref_code_o  (ref_code_o),
        .chan_sel_o  (chan_sel_o),
        .busy_o      (busy),
        .done_o      (done_o),
        .result_o    (result_o),
        .err_o       (err_o)
    );

    assign busy_o = busy;
endmodule

// File: tb/sar_adc_seq_tb_top.sv
`timescale 1ns/1ps
module sar_adc_seq_tb_top;
    localparam int SETTLE = 3;
    localparam int LAT    = 4 * SETTLE;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic [2:0] chan_i;
    logic       cmp_i;
    logic       ref_we_i;
    logic [3:0] ref_wdata_i;
    logic [3:0] ref_code_o;
    logic [5:0] chan_sel_o;
    logic       busy_o;
    logic       done_o;
    logic [3:0] result_o;
    logic       err_o;

    logic [3:0] vin [6];

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sar_adc_seq #(.SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .cmp_i(cmp_i),
        .ref_we_i(ref_we_i), .ref_wdata_i(ref_wdata_i), .ref_code_o(ref_code_o),
        .chan_sel_o(chan_sel_o), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .err_o(err_o)
    );

    // Ideal comparator: selected input at or above reference
    always_comb begin
        cmp_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (chan_sel_o[k]) cmp_i = (vin[k] >= ref_code_o);
        end
    end

    function automatic logic [3:0] expect_code(input logic [3:0] level);
        return level;
    endfunction

    function automatic logic [5:0] expect_sel(input int ch);
        return 6'(1) << ch;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one conversion; optional second start while busy (R8) and write while busy (R9)
    task automatic convert(input int ch, input bit extra_start, input bit write_busy);
        int lat;
        @(negedge clk);
        start_i = 1'b1; chan_i = 3'(ch);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy", busy_o, 1);
        check("R2 first code", ref_code_o, 4'b1000);
        check("R6 select", chan_sel_o, expect_sel(ch));
        check("R10 err clear", err_o, 0);
        if (write_busy) begin
            ref_we_i = 1'b1; ref_wdata_i = 4'hF;
        end
        if (extra_start) begin
            start_i = 1'b1; chan_i = 3'((ch + 1) % 6);
        end
        lat = 0;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            start_i = 1'b0; ref_we_i = 1'b0;
            lat++;
            if (write_busy && lat == 1) check("R9 write ignored busy", ref_code_o, 4'b1000);
            if (lat == 1 && SETTLE > 1) check("R3 ref held", ref_code_o, 4'b1000);
        end
        check("R5 latency", lat, LAT);
        check("R5 result", result_o, expect_code(vin[ch]));
        check("R5 idle at done", busy_o, 0);
        if (extra_start) check("R8 result of first channel", result_o, expect_code(vin[ch]));
        @(negedge clk);
        check("R5 done one cycle", done_o, 0);
        check("R6 select idle", chan_sel_o, 0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog R5 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start_i = 1'b0; chan_i = '0; ref_we_i = 1'b0; ref_wdata_i = '0;
        for (int k = 0; k < 6; k++) vin[k] = 4'(k * 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 ref", ref_code_o, 0);
        check("R1 result", result_o, 0);
        check("R1 sel", chan_sel_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check("R1 err", err_o, 0);

        // R9 direct write while idle
        @(negedge clk);
        ref_we_i = 1'b1; ref_wdata_i = 4'b0101;
        @(negedge clk);
        ref_we_i = 1'b0;
        check("R9 direct write", ref_code_o, 4'b0101);

        // Directed corners, R4 boundary values
        vin[0] = 4'h0;  convert(0, 0, 0);
        vin[5] = 4'hF;  convert(5, 0, 0);
        vin[2] = 4'h8;  convert(2, 0, 0);
        vin[3] = 4'h7;  convert(3, 0, 0);
        // R8 start during conversion
        vin[1] = 4'hA; vin[2] = 4'h3; convert(1, 1, 0);
        // R9 write during conversion
        vin[4] = 4'h0; convert(4, 0, 1);

        // R7 unused channel codes
        for (int c = 6; c < 8; c++) begin
            int dones;
            @(negedge clk);
            start_i = 1'b1; chan_i = 3'(c);
            @(negedge clk);
            start_i = 1'b0;
            check("R7 err set", err_o, 1);
            check("R7 not busy", busy_o, 0);
            dones = 0;
            for (int n = 0; n < LAT + 2; n++) begin
                @(negedge clk);
                if (done_o || busy_o) dones++;
            end
            check("R7 no conversion", dones, 0);
        end
        // R10 cleared by valid start (checked inside convert)
        vin[3] = 4'h9; convert(3, 0, 0);

        // Constrained random conversions, R5 R6
        for (int t = 0; t < 24; t++) begin
            int ch;
            for (int k = 0; k < 6; k++) vin[k] = 4'($urandom_range(0, 15));
            ch = $urandom_range(0, 5);
            convert(ch, 0, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end
endmodule